// File: doc/BRIEF.md
# Framed Receive Port to AXI4-Stream Bridge

This block takes packets from a 32-bit framed receive port and presents them on an AXI4-Stream master. On the receive port every handshake, delimiter and abort signal is active low. The port numbers its byte lanes big-endian from the left, and its valid-byte information comes as an active-low mask. The bridge moves each accepted beat into one output register. It reverses the lane order so that stream byte k carries receive lane k, and it builds `m_tkeep` from the mask on the closing beat of a frame.

The bridge also tracks frame state. An abort from the sender closes the packet with an error flag, and the rest of that frame is dropped. A start marker that arrives inside an open frame makes the bridge close the old frame with an empty error beat first. An end marker with no open frame is counted as a protocol error. Both of these set a sticky `proto_err` output. Header and footer markers are accepted and treated as ordinary payload. The bridge never asks the sender to stop.

Top module: `ll2axis_rx`

## Requirements
- R1: A beat moves on a rising edge where `up_valid_n` and `up_ready_n` are both low. An accepted beat that belongs to a frame appears on the stream one cycle later. Stream byte k, `m_tdata[8k+7:8k]`, equals receive lane k, and lane 0 is `up_data[31:24]`. Beats leave in arrival order.
- R2: When no close beat is pending (R8), `up_ready_n` is low exactly when `m_tvalid` is low or `m_tready` is high.
- R3: While `m_tvalid` is high and `m_tready` is low, the stream outputs hold their values.
- R4: On a beat with `up_end_n` low, `m_tkeep[k]` equals the inverse of `up_mask[3-k]`, so `up_mask[3]` qualifies lane 0 and a 0 bit marks a valid byte. On every other beat `m_tkeep` is all ones, whatever the mask holds.
- R5: `m_tlast` is high on the beat that carries `up_end_n` low. A beat with both `up_start_n` and `up_end_n` low forms a complete one-beat packet.
- R6: A beat accepted with `up_abort_n` low is sent with `m_tlast`=1 and `m_tuser`=1. After it, accepted beats are dropped until the next beat with `up_start_n` low, and no error is raised for those dropped beats.
- R7: A beat accepted outside a frame without `up_start_n` low is dropped. If that beat has `up_end_n` low, `proto_err` is set.
- R8: If `up_start_n` is low on a valid beat while a frame is open, `up_ready_n` stays high for that beat. Once the output register is free, a close beat with `m_tkeep`=0, `m_tlast`=1 and `m_tuser`=1 is emitted and `proto_err` is set. The held start beat then opens the new frame.
- R9: `proto_err` stays high once set, until reset.
- R10: `up_stop_n` is always high.
- R11: `up_hdr_n` and `up_ftr_n` have no effect on any output.
- R12: During reset, `m_tvalid` and `proto_err` are low and `up_ready_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_data | input | 32 | Receive data, lane 0 in bits 31:24 |
| up_mask | input | 4 | Active-low byte-valid mask, bit 3 for lane 0 |
| up_valid_n | input | 1 | Sender has a beat (active low) |
| up_ready_n | output | 1 | Bridge can take a beat (active low) |
| up_start_n | input | 1 | Frame start marker (active low) |
| up_end_n | input | 1 | Frame end marker (active low) |
| up_hdr_n | input | 1 | Header region marker, passed as payload |
| up_ftr_n | input | 1 | Footer region marker, passed as payload |
| up_abort_n | input | 1 | Sender aborts the packet (active low) |
| up_stop_n | output | 1 | Receiver abort request, held high |
| m_tdata | output | 32 | Stream data |
| m_tkeep | output | 4 | Stream byte qualifiers |
| m_tlast | output | 1 | Last beat of packet |
| m_tuser | output | 1 | Packet error flag |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| proto_err | output | 1 | Sticky frame-order error |

## Verification
The bench targets lane reversal and the mask: an end beat with a partial mask, and a mask full of junk on mid-frame beats. A design that reversed the wrong way, or read the mask on every beat, would emit wrong `m_tdata` or `m_tkeep`. It aborts a frame and then keeps sending that frame's beats, end marker included. A design that did not drop them would emit orphan beats, and one that flagged them would raise `proto_err` falsely. It sends a frame with no end marker followed by a new start. A design that missed the close beat, or accepted the start beat during the close cycle, would lose a beat or merge two packets. Random throttling on both sides shows whether the ready path or the output hold is wrong.

// File: rtl/ll2axis_rx.sv
module ll2axis_rx #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [8*BYTES-1:0] up_data,
  input  logic [BYTES-1:0]   up_mask,
  input  logic               up_valid_n,
  output logic               up_ready_n,
  input  logic               up_start_n,
  input  logic               up_end_n,
  input  logic               up_hdr_n,
  input  logic               up_ftr_n,
  input  logic               up_abort_n,
  output logic               up_stop_n,
  output logic [8*BYTES-1:0] m_tdata,
  output logic [BYTES-1:0]   m_tkeep,
  output logic               m_tlast,
  output logic               m_tuser,
  output logic               m_tvalid,
  input  logic               m_tready,
  output logic               proto_err
);
  localparam int DW = 8 * BYTES;

  typedef enum logic [1:0] {IDLE, OPEN, DROP} st_t;
  st_t st, st_nx;

  logic [DW-1:0]    lane_d;
  logic [BYTES-1:0] keep_d;

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign lane_d[8*k +: 8] = up_data[DW-1-8*k -: 8];
    assign keep_d[k]        = ~up_mask[BYTES-1-k];
  end

  logic sof, eof, abt, slot_free, need_close, close_now, xfer, take, stray;
  logic unused_delims;

  assign sof        = ~up_start_n;
  assign eof        = ~up_end_n;
  assign abt        = ~up_abort_n;
  assign slot_free  = ~m_tvalid | m_tready;
  assign need_close = (st == OPEN) & sof & ~up_valid_n;
  assign close_now  = need_close & slot_free;
  assign up_ready_n = ~(slot_free & ~need_close);
  assign xfer       = ~up_valid_n & ~up_ready_n;
  assign take       = xfer & (sof | (st == OPEN));
  assign stray      = xfer & eof & ~sof & (st == IDLE);
  assign up_stop_n  = 1'b1;
  assign unused_delims = &{1'b0, up_hdr_n, up_ftr_n};

  always_comb begin
    st_nx = st;
    if (close_now)
      st_nx = IDLE;
    else if (take)
      st_nx = abt ? DROP : (eof ? IDLE : OPEN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      m_tvalid  <= 1'b0;
      m_tdata   <= '0;
      m_tkeep   <= '0;
      m_tlast   <= 1'b0;
      m_tuser   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      st <= st_nx;
      if (close_now | stray)
        proto_err <= 1'b1;
      if (slot_free) begin
        m_tvalid <= close_now | take;
        if (close_now) begin
          m_tdata <= '0;
          m_tkeep <= '0;
          m_tlast <= 1'b1;
          m_tuser <= 1'b1;
        end else if (take) begin
          m_tdata <= lane_d;
          m_tkeep <= eof ? keep_d : '1;
          m_tlast <= eof | abt;
          m_tuser <= abt;
        end
      end
    end
  end
endmodule

// File: rtl/ll2axis_rx_chk.sv
module ll2axis_rx_chk #(
  parameter int BYTES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               up_start_n,
  input logic               up_ready_n,
  input logic               up_stop_n,
  input logic [8*BYTES-1:0] m_tdata,
  input logic [BYTES-1:0]   m_tkeep,
  input logic               m_tlast,
  input logic               m_tuser,
  input logic               m_tvalid,
  input logic               m_tready,
  input logic               proto_err
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
                              && $stable(m_tlast) && $stable(m_tuser));

  assert_ready_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_tvalid || m_tready) && up_start_n |-> !up_ready_n);

  assert_ready_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |-> up_ready_n);

  assert_full_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tlast |-> &m_tkeep);

  assert_err_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tuser |-> m_tlast);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  assert_no_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    up_stop_n);
endmodule

bind ll2axis_rx ll2axis_rx_chk #(.BYTES(BYTES)) u_chk (.*);

// File: tb/ll2axis_rx_tb.sv
`timescale 1ns/1ps
module ll2axis_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] up_data;
  logic [3:0]  up_mask;
  logic        up_valid_n, up_ready_n, up_start_n, up_end_n;
  logic        up_hdr_n, up_ftr_n, up_abort_n, up_stop_n;
  logic [31:0] m_tdata;
  logic [3:0]  m_tkeep;
  logic        m_tlast, m_tuser, m_tvalid, m_tready, proto_err;

  always #2.5 clk = ~clk;

  ll2axis_rx u_dut (.*);

  typedef struct packed {logic [31:0] d; logic [3:0] m; logic s, e, h, f, a;} beat_t;
  typedef struct packed {logic [31:0] d; logic [3:0] k; logic l, u, mk, hf;} exp_t;

  beat_t dq[$];
  exp_t  q[$];
  int checks = 0, fails = 0;
  int left = 0, pos = 0;
  bit no_end = 0;
  int ms = 0;          // 0 idle, 1 open, 2 drop
  bit exp_err = 0;

  function automatic logic [31:0] swap(logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [3:0] kdec(logic [3:0] m);
    return {~m[0], ~m[1], ~m[2], ~m[3]};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic add(logic [31:0] d, logic [3:0] m, bit s, bit e, bit h, bit f, bit a);
    beat_t b;
    b.d = d; b.m = m; b.s = s; b.e = e; b.h = h; b.f = f; b.a = a;
    dq.push_back(b);
  endtask

  task automatic gen(output beat_t b);
    b.d = $urandom; b.m = 4'($urandom); b.h = 0; b.f = 0; b.a = 0;
    if (left == 0) begin
      if ($urandom % 10 == 0) begin
        b.s = 0; b.e = ($urandom % 2 == 0);
        return;
      end
      left = 1 + $urandom % 18; pos = 0; no_end = ($urandom % 12 == 0);
    end
    b.s = (pos == 0);
    b.e = (left == 1) && !no_end;
    b.h = (pos == 1) && ($urandom % 2 == 0);
    b.f = (left == 2) && ($urandom % 2 == 0);
    b.a = ($urandom % 15 == 0);
    left--; pos++;
  endtask

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL R1: watchdog expired got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    beat_t cur;
    bit have = 0, rnd = 0, slot, xfer;
    exp_t e;
    void'($urandom(32'h5eed_1234));
    rst_n = 0; up_valid_n = 1; up_start_n = 1; up_end_n = 1; up_hdr_n = 1;
    up_ftr_n = 1; up_abort_n = 1; up_data = '0; up_mask = '0; m_tready = 0;
    repeat (4) @(negedge clk);
    #1;
    chk(!m_tvalid, "R12", "m_tvalid", 32'(m_tvalid), 0);
    chk(!proto_err, "R12", "proto_err", 32'(proto_err), 0);
    chk(!up_ready_n, "R12", "up_ready_n", 32'(up_ready_n), 0);
    @(negedge clk); rst_n = 1;

    // R1 R4: 16-beat frame, junk mask mid-frame must be ignored
    for (int i = 0; i < 16; i++) add(32'h1000_0000 + i * 32'h0101, 4'b1010, i == 0, i == 15, 0, 0, 0);
    // R4 R5: single-beat frame, lanes 0 and 1 valid -> tkeep 0011
    add(32'hAABBCCDD, 4'b0011, 1, 1, 0, 0, 0);
    // R11: header and footer markers, end mask keeps only lane 0
    add(32'h01020304, 4'b1111, 1, 0, 0, 0, 0);
    add(32'h05060708, 4'b0000, 0, 0, 1, 0, 0);
    add(32'h090A0B0C, 4'b0111, 0, 1, 0, 1, 0);
    // R7: stray data beat and stray end beat
    add(32'hDEAD0001, 4'b0000, 0, 0, 0, 0, 0);
    add(32'hDEAD0002, 4'b0000, 0, 1, 0, 0, 0);
    // R6: abort on beat 2, rest of frame dropped
    for (int i = 0; i < 5; i++) add(32'h2000_0000 + i, 4'b0000, i == 0, i == 4, 0, 0, i == 2);
    // R8: frame with no end, then a new frame
    for (int i = 0; i < 3; i++) add(32'h3000_0000 + i, 4'b0000, i == 0, 0, 0, 0, 0);
    for (int i = 0; i < 2; i++) add(32'h4000_0000 + i, 4'b1100, i == 0, i == 1, 0, 0, 0);

    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      if (!have) begin
        if (dq.size() > 0) begin cur = dq.pop_front(); have = 1; end
        else if (rnd || cyc > 200) begin rnd = 1; gen(cur); have = 1; end
      end
      up_valid_n = !(have && ($urandom % 4 != 0));
      up_data = cur.d; up_mask = cur.m; up_start_n = !cur.s; up_end_n = !cur.e;
      up_hdr_n = !cur.h; up_ftr_n = !cur.f; up_abort_n = !cur.a;
      m_tready = ($urandom % 10 < 7);
      #1;
      chk(up_stop_n, "R10", "up_stop_n", 32'(up_stop_n), 1);
      chk(proto_err == exp_err, "R9", "proto_err", 32'(proto_err), 32'(exp_err));
      if (m_tvalid && m_tready) begin
        if (q.size() == 0) begin
          chk(0, "R1", "unexpected beat", m_tdata, 0);
        end else begin
          e = q.pop_front();
          chk(m_tdata == e.d, e.hf ? "R11" : "R1", "m_tdata", m_tdata, e.d);
          chk(m_tkeep == e.k, e.mk ? "R8" : "R4", "m_tkeep", 32'(m_tkeep), 32'(e.k));
          chk(m_tlast == e.l, e.mk ? "R8" : "R5", "m_tlast", 32'(m_tlast), 32'(e.l));
          chk(m_tuser == e.u, e.mk ? "R8" : "R6", "m_tuser", 32'(m_tuser), 32'(e.u));
        end
      end
      slot = !m_tvalid || m_tready;
      if (!up_valid_n && ms == 1 && cur.s) begin
        chk(up_ready_n, "R8", "up_ready_n on start in open frame", 32'(up_ready_n), 1);
        if (slot) begin
          e = '{d: 0, k: 0, l: 1, u: 1, mk: 1, hf: 0};
          q.push_back(e); ms = 0; exp_err = 1;
        end
      end else begin
        chk(up_ready_n == !slot, "R2", "up_ready_n", 32'(up_ready_n), 32'(!slot));
        xfer = !up_valid_n && !up_ready_n;
        if (xfer) begin
          have = 0;
          if (cur.s || ms == 1) begin
            e.d = swap(cur.d); e.k = cur.e ? kdec(cur.m) : 4'hF;
            e.l = cur.e || cur.a; e.u = cur.a; e.mk = 0; e.hf = cur.h || cur.f;
            q.push_back(e);
            ms = cur.a ? 2 : (cur.e ? 0 : 1);
          end else if (cur.e && ms == 0) begin
            exp_err = 1;
          end
        end
      end
    end

    @(negedge clk); up_valid_n = 1; m_tready = 1;
    for (int i = 0; i < 4; i++) begin
      #1;
      if (m_tvalid) begin
        if (q.size() == 0) chk(0, "R1", "unexpected beat", m_tdata, 0);
        else begin
          e = q.pop_front();
          chk(m_tdata == e.d, "R1", "m_tdata drain", m_tdata, e.d);
        end
      end
      @(negedge clk);
    end
    chk(q.size() == 0, "R1", "beats left undelivered", 32'(q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule